// File: doc/BRIEF.md
# Address-Space-Tagged Virtual Line Cache

This block is a direct-mapped cache whose lookup uses the virtual address alone: the set index and the stored tag both come from the virtual address, so no translation sits in the hit path. Each line also records the identifier of the address space that filled it, and a line only hits when that identifier equals the current one. Several processes can therefore share the array without reading each other's data, and no flush is needed on every process switch.

Translation is needed only on a miss. The block then raises a request carrying the virtual address and identifier to an external unit, which translates the address, fetches the 16-byte line and hands it back. The line is written into the array and the requested word is returned. Software keeps the array consistent after a page is remapped with two commands: a sweep that clears every line, and a single-line clear addressed by a raw set number rather than by an address.

Top module: `asid_vcache`

## Requirements
- R1: The array holds 256 lines of 16 bytes. A lookup uses virtual bits [11:4] as the set number and bits [31:12] as the tag, and returns the 32-bit word picked by bits [3:2] (word k occupies line bits [32k+31:32k]).
- R2: A lookup hits only when the line at its set is valid and both the stored tag and the stored identifier equal the request's. On a hit `resp_valid` rises with `resp_hit`=1 in the second cycle after the edge that accepted the request, and no translation request is raised.
- R3: On a miss `xlat_req_valid` is raised with the latched virtual address and identifier and held until `xlat_resp_valid`. At that edge the returned line is written, and in the following cycle `resp_valid` is high with `resp_hit`=0 and the word taken from the returned line.
- R4: The current identifier is 8 bits, loaded by `asid_wr_en`. A request takes the value held before its acceptance edge, so a write in the same cycle applies from the next request onward.
- R5: `flush_all` clears one set per cycle from set 0 to set 255. `busy` stays high for exactly 256 cycles after the accepting edge, and every set misses afterwards.
- R6: `inv_line_valid` clears only the line at set `inv_line_idx`, in one cycle and without raising `busy`; all other lines keep hitting.
- R7: When a maintenance command and a lookup arrive together, the command is taken and `req_ready` stays low; the held lookup is accepted once the block is free again. A whole-array flush takes precedence over a single-line clear.
- R8: Lookups and maintenance commands are taken only while `busy` is low; a command presented while a lookup is in flight is ignored, and `req_ready` is low whenever `busy` is high.
- R9: After the backing of a page changes, a line still present returns its old data, and once that line is cleared the next lookup misses and returns the new data.
- R10: After reset every line is invalid, `busy`, `resp_valid` and `xlat_req_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_wr_en | input | 1 | Load the current address-space identifier |
| asid_wr_val | input | 8 | New identifier value |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_ready | output | 1 | Lookup taken at this edge when high |
| resp_valid | output | 1 | Lookup result valid for one cycle |
| resp_hit | output | 1 | Result came from the array (1) or from a refill (0) |
| resp_word | output | 32 | Returned word |
| flush_all | input | 1 | Clear every line |
| inv_line_valid | input | 1 | Clear the line at a raw set number |
| inv_line_idx | input | 8 | Set number to clear |
| busy | output | 1 | Lookup in flight or flush sweep running |
| xlat_req_valid | output | 1 | Miss: translation and fill requested |
| xlat_req_vaddr | output | 32 | Virtual address of the missing lookup |
| xlat_req_asid | output | 8 | Identifier of the missing lookup |
| xlat_resp_valid | input | 1 | Translated line returned |
| xlat_resp_line | input | 128 | Returned line contents |

## Verification
A wrong valid bit, stored tag or stored identifier shows at the ports on the very next lookup to that set: `resp_hit` flips and a translation request appears or fails to appear two cycles after acceptance, and the returned word differs from the line contents the bench expects. Sweeping every set through fill, hit, flush and single-line clear exposes any set whose state is mishandled within one lookup, and a miscounted flush sweep shows directly as a `busy` width other than 256 cycles. Identifier handling is exposed by re-reading filled sets under a different identifier, including a load of the identifier in the same cycle as a request.

// File: rtl/asid_vcache_pkg.sv
package asid_vcache_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CMP   = 2'd1,
    S_WAIT  = 2'd2,
    S_FLUSH = 2'd3
  } vc_state_e;
endpackage

// File: rtl/avc_tag_store.sv
module avc_tag_store #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [ASID_W-1:0] cmp_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic              hit
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [ASID_W-1:0] asid_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic set_i;
    logic clr_i;
    assign set_i = wr_en  && (wr_idx  == IDX_W'(i));
    assign clr_i = clr_en && (clr_idx == IDX_W'(i));
    assign valid_d[i] = set_i ? 1'b1 : (clr_i ? 1'b0 : valid_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      asid_q[wr_idx] <= wr_asid;
    end
  end

  always_comb begin
    hit = valid_q[rd_idx] && (tag_q[rd_idx] == cmp_tag) && (asid_q[rd_idx] == cmp_asid);
  end

  // R5 / R6: a cleared set reads invalid on the following cycle
  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> !valid_q[$past(clr_idx)]);

  // R3: a refilled set reads valid on the following cycle
  assert_fill_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/avc_data_store.sv
module avc_data_store #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [(8<<OFF_W)-1:0]   wr_line,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [OFF_W-3:0]        rd_sel,
  output logic [WORD_W-1:0]       rd_word
);
  localparam int unsigned LINES  = 1 << IDX_W;
  localparam int unsigned LINE_W = 8 << OFF_W;

  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_line;
  end

  always_comb begin
    rd_word = mem_q[rd_idx][rd_sel*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/avc_ctrl.sv
module avc_ctrl
  import asid_vcache_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asid_wr_en,
  input  logic [ASID_W-1:0] asid_wr_val,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  input  logic              flush_all,
  input  logic              inv_line_valid,
  input  logic [IDX_W-1:0]  inv_line_idx,
  input  logic              hit,
  input  logic [WORD_W-1:0] store_word,
  input  logic [WORD_W-1:0] fill_word,
  input  logic              xlat_resp_valid,
  output logic              xlat_req_valid,
  output logic [VA_W-1:0]   lat_vaddr,
  output logic [ASID_W-1:0] lat_asid,
  output logic              fill_en,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WORD_W-1:0] resp_word
);
  localparam int unsigned LINES = 1 << IDX_W;

  vc_state_e         state_q, state_d;
  logic [IDX_W-1:0]  fcnt_q, fcnt_d;
  logic [ASID_W-1:0] cur_asid_q;
  logic [VA_W-1:0]   lat_vaddr_q;
  logic [ASID_W-1:0] lat_asid_q;
  logic              resp_valid_q, resp_valid_d;
  logic              resp_hit_q, resp_hit_d;
  logic [WORD_W-1:0] resp_word_q, resp_word_d;
  logic              idle;
  logic              accept;
  logic              line_clr;
  logic              fcnt_en;
  logic              resp_en;

  assign idle      = (state_q == S_IDLE);
  assign req_ready = idle && !flush_all && !inv_line_valid;
  assign accept    = req_valid && req_ready;
  assign line_clr  = idle && !flush_all && inv_line_valid;
  assign fill_en   = (state_q == S_WAIT) && xlat_resp_valid;
  assign fcnt_en   = (idle && flush_all) || (state_q == S_FLUSH);

  always_comb begin
    state_d = state_q;
    fcnt_d  = fcnt_q;
    unique case (state_q)
      S_IDLE: begin
        if (flush_all) begin
          state_d = S_FLUSH;
          fcnt_d  = '0;
        end else if (accept) begin
          state_d = S_CMP;
        end
      end
      S_CMP:   state_d = hit ? S_IDLE : S_WAIT;
      S_WAIT:  if (xlat_resp_valid) state_d = S_IDLE;
      S_FLUSH: begin
        fcnt_d = fcnt_q + 1'b1;
        if (fcnt_q == IDX_W'(LINES - 1)) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    resp_valid_d = ((state_q == S_CMP) && hit) || fill_en;
    resp_hit_d   = (state_q == S_CMP) && hit;
    resp_word_d  = (state_q == S_CMP) ? store_word : fill_word;
    resp_en      = resp_valid_d || resp_valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      fcnt_q       <= '0;
      cur_asid_q   <= '0;
      lat_vaddr_q  <= '0;
      lat_asid_q   <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fcnt_en)    fcnt_q     <= fcnt_d;
      if (asid_wr_en) cur_asid_q <= asid_wr_val;
      if (accept) begin
        lat_vaddr_q <= req_vaddr;
        lat_asid_q  <= cur_asid_q;
      end
      if (resp_en) begin
        resp_valid_q <= resp_valid_d;
        resp_hit_q   <= resp_hit_d;
        resp_word_q  <= resp_word_d;
      end
    end
  end

  assign clr_en         = line_clr || (state_q == S_FLUSH);
  assign clr_idx        = (state_q == S_FLUSH) ? fcnt_q : inv_line_idx;
  assign xlat_req_valid = (state_q == S_WAIT);
  assign lat_vaddr      = lat_vaddr_q;
  assign lat_asid       = lat_asid_q;
  assign busy           = !idle;
  assign resp_valid     = resp_valid_q;
  assign resp_hit       = resp_hit_q;
  assign resp_word      = resp_word_q;

  // R7: a maintenance command in an idle cycle blocks the lookup
  assert_maint_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (flush_all || inv_line_valid)) |-> !req_ready);

  // R8: nothing is accepted while busy
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R3: translation request starts only after a failed compare
  assert_xlat_after_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xlat_req_valid) |-> ($past(state_q) == S_CMP) && !$past(hit));

  // R3: translation request held until answered
  assert_xlat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req_valid && !xlat_resp_valid) |=> xlat_req_valid);

  // R2: a result only follows a compare or a refill
  assert_resp_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> ($past(state_q) == S_CMP) || ($past(state_q) == S_WAIT));

  // R6: a single-line clear leaves the block idle
  assert_line_clr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_clr |=> !busy);

  // R5: the sweep is entered only from idle on a flush command
  assert_flush_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FLUSH && $past(state_q) != S_FLUSH) |-> $past(flush_all));
endmodule

// File: rtl/asid_vcache.sv
module asid_vcache
  import asid_vcache_pkg::*;
#(
  parameter int unsigned P_VA_W   = VA_W,
  parameter int unsigned P_IDX_W  = IDX_W,
  parameter int unsigned P_OFF_W  = OFF_W,
  parameter int unsigned P_ASID_W = ASID_W,
  parameter int unsigned P_WORD_W = WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      asid_wr_en,
  input  logic [P_ASID_W-1:0]       asid_wr_val,
  input  logic                      req_valid,
  input  logic [P_VA_W-1:0]         req_vaddr,
  output logic                      req_ready,
  output logic                      resp_valid,
  output logic                      resp_hit,
  output logic [P_WORD_W-1:0]       resp_word,
  input  logic                      flush_all,
  input  logic                      inv_line_valid,
  input  logic [P_IDX_W-1:0]        inv_line_idx,
  output logic                      busy,
  output logic                      xlat_req_valid,
  output logic [P_VA_W-1:0]         xlat_req_vaddr,
  output logic [P_ASID_W-1:0]       xlat_req_asid,
  input  logic                      xlat_resp_valid,
  input  logic [(8<<P_OFF_W)-1:0]   xlat_resp_line
);
  localparam int unsigned TAG_W  = P_VA_W - P_IDX_W - P_OFF_W;
  localparam int unsigned SEL_W  = P_OFF_W - 2;
  localparam int unsigned TAG_LO = P_IDX_W + P_OFF_W;

  logic                rst_meta_q, rst_sync_q;
  logic                hit;
  logic [P_WORD_W-1:0] store_word;
  logic [P_WORD_W-1:0] fill_word;
  logic [P_VA_W-1:0]   lat_vaddr;
  logic [P_ASID_W-1:0] lat_asid;
  logic                fill_en;
  logic                clr_en;
  logic [P_IDX_W-1:0]  clr_idx;
  logic [P_IDX_W-1:0]  lat_idx;
  logic [TAG_W-1:0]    lat_tag;
  logic [SEL_W-1:0]    lat_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign lat_idx   = lat_vaddr[P_OFF_W +: P_IDX_W];
  assign lat_tag   = lat_vaddr[TAG_LO +: TAG_W];
  assign lat_sel   = lat_vaddr[2 +: SEL_W];
  assign fill_word = xlat_resp_line[lat_sel*P_WORD_W +: P_WORD_W];

  avc_ctrl #(
    .VA_W(P_VA_W), .IDX_W(P_IDX_W), .ASID_W(P_ASID_W), .WORD_W(P_WORD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_q),
    .asid_wr_en(asid_wr_en), .asid_wr_val(asid_wr_val),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .flush_all(flush_all), .inv_line_valid(inv_line_valid), .inv_line_idx(inv_line_idx),
    .hit(hit), .store_word(store_word), .fill_word(fill_word),
    .xlat_resp_valid(xlat_resp_valid), .xlat_req_valid(xlat_req_valid),
    .lat_vaddr(lat_vaddr), .lat_asid(lat_asid), .fill_en(fill_en),
    .clr_en(clr_en), .clr_idx(clr_idx), .busy(busy),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_word(resp_word)
  );

  avc_tag_store #(
    .IDX_W(P_IDX_W), .TAG_W(TAG_W), .ASID_W(P_ASID_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_sync_q),
    .rd_idx(lat_idx), .cmp_tag(lat_tag), .cmp_asid(lat_asid),
    .wr_en(fill_en), .wr_idx(lat_idx), .wr_tag(lat_tag), .wr_asid(lat_asid),
    .clr_en(clr_en), .clr_idx(clr_idx), .hit(hit)
  );

  avc_data_store #(
    .IDX_W(P_IDX_W), .OFF_W(P_OFF_W), .WORD_W(P_WORD_W)
  ) u_data (
    .clk(clk), .wr_en(fill_en), .wr_idx(lat_idx), .wr_line(xlat_resp_line),
    .rd_idx(lat_idx), .rd_sel(lat_sel), .rd_word(store_word)
  );

  assign xlat_req_vaddr = lat_vaddr;
  assign xlat_req_asid  = lat_asid;
endmodule

// File: tb/tb_asid_vcache.sv
module tb_asid_vcache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         asid_wr_en = 1'b0;
  logic [7:0]   asid_wr_val = '0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_vaddr = '0;
  logic         req_ready;
  logic         resp_valid, resp_hit;
  logic [31:0]  resp_word;
  logic         flush_all = 1'b0;
  logic         inv_line_valid = 1'b0;
  logic [7:0]   inv_line_idx = '0;
  logic         busy;
  logic         xlat_req_valid;
  logic [31:0]  xlat_req_vaddr;
  logic [7:0]   xlat_req_asid;
  logic         xlat_resp_valid = 1'b0;
  logic [127:0] xlat_resp_line = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench reference state, derived from the requirements
  bit          m_valid [256];
  logic [19:0] m_tag   [256];
  logic [7:0]  m_asid  [256];
  int          m_gen   [256];
  logic [7:0]  cur_asid = '0;
  int          gen = 0;

  always #10 clk = ~clk;

  asid_vcache dut (
    .clk(clk), .rst_n(rst_n), .asid_wr_en(asid_wr_en), .asid_wr_val(asid_wr_val),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_word(resp_word),
    .flush_all(flush_all), .inv_line_valid(inv_line_valid), .inv_line_idx(inv_line_idx),
    .busy(busy), .xlat_req_valid(xlat_req_valid), .xlat_req_vaddr(xlat_req_vaddr),
    .xlat_req_asid(xlat_req_asid), .xlat_resp_valid(xlat_resp_valid),
    .xlat_resp_line(xlat_resp_line)
  );

  function automatic logic [31:0] word_of(logic [27:0] line_addr, logic [7:0] a, int g, int w);
    return {line_addr, w[1:0], 2'b00} ^ {a, a, a, a} ^ (32'(g) * 32'h0101_0101);
  endfunction

  function automatic logic [127:0] line_of(logic [27:0] line_addr, logic [7:0] a, int g);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of(line_addr, a, g, w);
    return l;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // translation and fill unit model: answers two cycles after a request appears
  initial begin
    forever begin
      @(negedge clk);
      if (xlat_req_valid && !xlat_resp_valid) begin
        repeat (2) @(negedge clk);
        xlat_resp_line  = line_of(xlat_req_vaddr[31:4], xlat_req_asid, gen);
        xlat_resp_valid = 1'b1;
        @(negedge clk);
        xlat_resp_valid = 1'b0;
      end
    end
  end

  // one lookup; new_asid>=0 loads the identifier in the acceptance cycle,
  // inv_mid>=0 presents a single-line clear while the lookup is in flight
  task automatic access(logic [31:0] va, string req, int new_asid = -1, int inv_mid = -1);
    int idx = int'(va[11:4]);
    int w = int'(va[3:2]);
    logic [7:0] use_asid;
    bit exp_hit;
    logic [31:0] exp_word;
    bit saw_x = 1'b0;
    bit x_ok = 1'b1;
    int t = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    if (new_asid >= 0) begin
      asid_wr_en = 1'b1;
      asid_wr_val = 8'(new_asid);
    end
    use_asid = cur_asid;
    @(negedge clk);
    req_valid = 1'b0;
    asid_wr_en = 1'b0;
    if (new_asid >= 0) cur_asid = 8'(new_asid);
    exp_hit = m_valid[idx] && m_tag[idx] == va[31:12] && m_asid[idx] == use_asid;
    if (exp_hit) exp_word = word_of({m_tag[idx], va[11:4]}, m_asid[idx], m_gen[idx], w);
    else         exp_word = word_of(va[31:4], use_asid, gen, w);
    if (inv_mid >= 0) begin
      inv_line_valid = 1'b1;
      inv_line_idx = 8'(inv_mid);
    end
    while (!resp_valid && t < 40) begin
      if (xlat_req_valid) begin
        saw_x = 1'b1;
        if (xlat_req_vaddr != va || xlat_req_asid != use_asid) x_ok = 1'b0;
      end
      @(negedge clk);
      inv_line_valid = 1'b0;
      t++;
    end
    chk(resp_valid, req, "response arrives", 32'(resp_valid), 32'd1);
    chk(resp_hit == exp_hit, exp_hit ? "R2" : "R3", "hit flag", 32'(resp_hit), 32'(exp_hit));
    chk(saw_x == !exp_hit, "R3", "translation only on miss", 32'(saw_x), 32'(!exp_hit));
    chk(x_ok, "R3", "translation request fields", xlat_req_vaddr, va);
    chk(resp_word == exp_word, req, "returned word (R1)", resp_word, exp_word);
    if (!exp_hit) begin
      m_valid[idx] = 1'b1;
      m_tag[idx] = va[31:12];
      m_asid[idx] = use_asid;
      m_gen[idx] = gen;
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    for (int i = 0; i < 256; i++) m_valid[i] = 1'b0;
  endtask

  task automatic do_inv(int idx);
    @(negedge clk);
    inv_line_valid = 1'b1;
    inv_line_idx = 8'(idx);
    @(negedge clk);
    inv_line_valid = 1'b0;
    chk(!busy, "R6", "busy after line clear", 32'(busy), 32'd0);
    m_valid[idx] = 1'b0;
  endtask

  function automatic logic [31:0] va_of(int tag, int idx, int w);
    return {20'(tag), 8'(idx), 2'(w), 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) m_valid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!busy, "R10", "busy", 32'(busy), 0);
    chk(!resp_valid, "R10", "resp_valid", 32'(resp_valid), 0);
    chk(!xlat_req_valid, "R10", "xlat_req_valid", 32'(xlat_req_valid), 0);
    chk(req_ready, "R10", "req_ready", 32'(req_ready), 1);

    // R1/R3: every set misses once, then R2: every set hits
    for (int i = 0; i < 256; i++) access(va_of(i * 7 + 3, i, i % 4), "R1");
    for (int i = 0; i < 256; i++) access(va_of(i * 7 + 3, i, (i + 1) % 4), "R2");

    // R1: conflicting tag on the same set replaces the line
    access(va_of(999, 17, 0), "R1");
    access(va_of(17 * 7 + 3, 17, 2), "R1");

    // R4: another identifier misses, returning to the first misses again (replaced)
    access(va_of(500, 40, 1), "R4", 8'h5A);
    access(va_of(500, 40, 1), "R4");
    access(va_of(500, 40, 3), "R4", 8'h00);
    access(va_of(500, 40, 3), "R4");
    // R4: write in the acceptance cycle applies from the next request
    access(va_of(60 * 7 + 3, 60, 0), "R4", 8'h33);
    access(va_of(60 * 7 + 3, 60, 1), "R4");
    access(va_of(60 * 7 + 3, 60, 1), "R4", 8'h00);

    // R6: single-line clear affects only its set
    access(va_of(8, 90, 0), "R6");
    access(va_of(9, 91, 0), "R6");
    do_inv(90);
    access(va_of(8, 90, 1), "R6");
    access(va_of(9, 91, 1), "R6");

    // R8: clear presented while a lookup is in flight is ignored
    access(va_of(10, 120, 0), "R8");
    access(va_of(11, 121, 0), "R8", -1, 120);
    access(va_of(10, 120, 2), "R8");
    access(va_of(10, 120, 2), "R8", -1, 120);
    access(va_of(10, 120, 3), "R8");

    // R9: remapped backing; old line stays until cleared
    gen = 1;
    access(va_of(10, 120, 1), "R9");
    do_inv(120);
    access(va_of(10, 120, 1), "R9");
    access(va_of(10, 120, 0), "R9");

    // R5: flush sweep length and result
    do_flush();
    n = 0;
    while (busy && n < 400) begin
      n++;
      @(negedge clk);
    end
    chk(n == 256, "R5", "busy cycles of flush", 32'(n), 32'd256);
    for (int i = 0; i < 256; i++) access(va_of(i * 7 + 3, i, 0), "R5");

    // R7: flush and lookup together: flush wins, lookup held then served as miss
    @(negedge clk);
    flush_all = 1'b1;
    inv_line_valid = 1'b1;
    inv_line_idx = 8'd5;
    req_valid = 1'b1;
    req_vaddr = va_of(5 * 7 + 3, 5, 0);
    #1;
    chk(!req_ready, "R7", "req_ready with command", 32'(req_ready), 0);
    @(negedge clk);
    flush_all = 1'b0;
    inv_line_valid = 1'b0;
    chk(busy, "R7", "flush taken over lookup and line clear", 32'(busy), 1);
    chk(!req_ready, "R8", "req_ready while busy", 32'(req_ready), 0);
    for (int i = 0; i < 256; i++) m_valid[i] = 1'b0;
    access(va_of(5 * 7 + 3, 5, 0), "R7");
    access(va_of(6 * 7 + 3, 6, 0), "R5");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule